// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Burst SRAM

This block is a synthesizable behavioural model of a synchronous pipelined static RAM whose data bus never needs an idle cycle between a write and a read. Each enabled clock edge accepts one command: a load that opens a new burst, or an advance that steps the current burst by one beat. A load only opens a burst when all three chip selects are asserted, and its write-enable decides whether the whole burst reads or writes. The data bus is 18 bits wide, split into two 9-bit byte lanes, each with its own active-low write enable. The array is kept small.

Every access has its data phase a fixed two enabled clocks after its address. A write followed at once by a read therefore shares no bus cycle. A read can still reach an address whose write data is on the bus in the very cycle the read's array lookup runs. In that case the pending bytes are forwarded lane by lane, and the array's stale contents are not returned. A clock-enable input freezes the whole pipeline, outputs included. A 2-bit beat counter produces four-beat bursts in either linear or interleaved order.

Top module: `zbt_sram`

## Requirements
- R1: While `clk_en_n` is high, no input is sampled, the array is not written, and the pipeline and the data on `dq` stay as they were.
- R2: A load (`adv_ld` low) opens a burst only when `sel1_n` is low, `sel2` is high and `sel3_n` is low. Any other combination deselects: no access happens and the bus stays released in that command's data slot.
- R3: An advance (`adv_ld` high) steps the beat counter whatever the chip selects and `we_n` show. An advance after a deselect continues to access nothing.
- R4: `we_n` is sampled only at a load (low = write, high = read). Every beat of the burst keeps that type, even if `we_n` toggles during advances.
- R5: Beat k (k = 0..3, counted from the load) addresses the load address with its two low bits replaced. When `interleave` is high they become start XOR k. When it is low they become start + k modulo 4. The upper address bits never change.
- R6: Write data is taken from `dq` at the second enabled edge after the beat's address. `bwe_n[0]` guards `dq[8:0]` and `bwe_n[1]` guards `dq[17:9]`, active low, and both are sampled with each beat's address. A write beat with both bits high stores nothing.
- R7: A read beat's data is driven on `dq` after the first enabled edge following its address. It stays there until the second, which is the data slot two enabled clocks after the address. It is driven only while `oe_n` is low.
- R8: A read issued immediately after a write to the same address returns, per lane, the new bytes of the enabled lanes and the old array bytes of the others.
- R9: In a data slot belonging to no read (a deselect, a write, or an empty pipeline), `dq` is released to high impedance, so the bus drains two enabled clocks after a deselect.
- R10: After reset the pipeline holds no access and `dq` is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the pipeline |
| clk_en_n | input | 1 | Active-low clock enable for all synchronous inputs |
| sel1_n | input | 1 | Chip select, active low |
| sel2 | input | 1 | Chip select, active high |
| sel3_n | input | 1 | Chip select, active low |
| adv_ld | input | 1 | High = advance current burst, low = load new command |
| we_n | input | 1 | Write enable at load, active low |
| bwe_n | input | LANES (2) | Per-lane write enables, active low |
| interleave | input | 1 | High = interleaved burst order, low = linear |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W (6) | Word address sampled at load |
| dq | inout | LANES*LANE_W (18) | Bidirectional data bus |

## Verification
The two functions that collide are the commit of a write beat and the array lookup of the read right behind it. Both run on the same enabled edge, so the read must take its bytes from the bus and not from the array. The sweep provokes this by issuing a write load and then a read load of the same address. It steps the write's lane mask through all four values, including the mask that stores nothing. The bench judges each returned word against a reference array that it updates lane by lane in bus-slot order. Clock-enable stalls inserted between those two commands show that the merge still holds when the edge is held back.

// File: rtl/zbt_pkg.sv
package zbt_pkg;

    // Kind of access held in one pipeline stage
    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_RD   = 2'd1,
        OP_WR   = 2'd2
    } op_e;

endpackage

// File: rtl/zbt_burst_addr.sv
module zbt_burst_addr #(
    parameter int unsigned ADDR_W = 6
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [1:0]        step,
    input  logic              interleave,
    output logic [ADDR_W-1:0] beat
);
    localparam int unsigned HI_W = ADDR_W - 2;

    logic [1:0] low;

    always_comb begin
        if (interleave) begin
            low = base[1:0] ^ step;
        end else begin
            low = base[1:0] + step;
        end
        beat = {base[ADDR_W-1 -: HI_W], low};
    end
endmodule

// File: rtl/zbt_lane_merge.sv
module zbt_lane_merge #(
    parameter int unsigned LANES  = 2,
    parameter int unsigned LANE_W = 9,
    localparam int unsigned DATA_W = LANES * LANE_W
) (
    input  logic [LANES-1:0]  take_bus,
    input  logic [DATA_W-1:0] from_mem,
    input  logic [DATA_W-1:0] from_bus,
    output logic [DATA_W-1:0] merged
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign merged[g*LANE_W +: LANE_W] = take_bus[g] ? from_bus[g*LANE_W +: LANE_W]
                                                        : from_mem[g*LANE_W +: LANE_W];
    end
endmodule

// File: rtl/zbt_mem_array.sv
module zbt_mem_array #(
    parameter int unsigned ADDR_W = 6,
    parameter int unsigned LANES  = 2,
    parameter int unsigned LANE_W = 9,
    localparam int unsigned DATA_W = LANES * LANE_W
) (
    input  logic              clk,
    input  logic [LANES-1:0]  wr_lane,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    localparam int unsigned DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] cells [DEPTH];

        always_ff @(posedge clk) begin
            if (wr_lane[g]) begin
                cells[wr_addr] <= wr_data[g*LANE_W +: LANE_W];
            end
        end

        assign rd_data[g*LANE_W +: LANE_W] = cells[rd_addr];
    end
endmodule

// File: rtl/zbt_sram.sv
module zbt_sram
    import zbt_pkg::*;
#(
    parameter int unsigned ADDR_W = 6,
    parameter int unsigned LANES  = 2,
    parameter int unsigned LANE_W = 9,
    localparam int unsigned DATA_W = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_en_n,
    input  logic              sel1_n,
    input  logic              sel2,
    input  logic              sel3_n,
    input  logic              adv_ld,
    input  logic              we_n,
    input  logic [LANES-1:0]  bwe_n,
    input  logic              interleave,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    inout  wire  [DATA_W-1:0] dq
);
    typedef struct packed {
        op_e               op;
        logic [ADDR_W-1:0] addr;
        logic [LANES-1:0]  lanes;
    } beat_t;

    typedef struct packed {
        logic              active;
        logic              is_wr;
        logic [ADDR_W-1:0] base;
        logic [1:0]        cnt;
        beat_t             s1;
        beat_t             s2;
        logic [DATA_W-1:0] rd;
    } state_t;

    state_t st_d, st_q;
    beat_t  beat;

    logic              selected;
    logic [1:0]        adv_cnt;
    logic [ADDR_W-1:0] beat_addr;
    logic              wr_commit;
    logic [LANES-1:0]  commit_lanes;
    logic [LANES-1:0]  fwd_lanes;
    logic [DATA_W-1:0] mem_word;
    logic [DATA_W-1:0] fresh_word;
    logic              drive_en;

    assign selected = !sel1_n && sel2 && !sel3_n;
    assign adv_cnt  = st_q.cnt + 2'd1;

    zbt_burst_addr #(.ADDR_W(ADDR_W)) i_burst (
        .base       (st_q.base),
        .step       (adv_cnt),
        .interleave (interleave),
        .beat       (beat_addr)
    );

    // Write beat in stage 2 takes its data from the bus on this edge
    assign wr_commit    = !clk_en_n && (st_q.s2.op == OP_WR);
    assign commit_lanes = wr_commit ? st_q.s2.lanes : '0;

    // Read in stage 1 that meets the write whose data is on the bus now
    assign fwd_lanes = ((st_q.s2.op == OP_WR) && (st_q.s2.addr == st_q.s1.addr))
                       ? st_q.s2.lanes : '0;

    zbt_mem_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) i_mem (
        .clk     (clk),
        .wr_lane (commit_lanes),
        .wr_addr (st_q.s2.addr),
        .wr_data (dq),
        .rd_addr (st_q.s1.addr),
        .rd_data (mem_word)
    );

    zbt_lane_merge #(.LANES(LANES), .LANE_W(LANE_W)) i_merge (
        .take_bus (fwd_lanes),
        .from_mem (mem_word),
        .from_bus (dq),
        .merged   (fresh_word)
    );

    always_comb begin
        st_d       = st_q;
        beat.op    = OP_NONE;
        beat.addr  = addr;
        beat.lanes = ~bwe_n;
        if (!clk_en_n) begin
            if (!adv_ld) begin
                if (selected) begin
                    st_d.active = 1'b1;
                    st_d.is_wr  = !we_n;
                    st_d.base   = addr;
                    st_d.cnt    = 2'd0;
                    beat.op     = we_n ? OP_RD : OP_WR;
                end else begin
                    st_d.active = 1'b0;
                end
            end else begin
                st_d.cnt  = adv_cnt;
                beat.addr = beat_addr;
                if (st_q.active) begin
                    beat.op = st_q.is_wr ? OP_WR : OP_RD;
                end
            end
            st_d.s1 = beat;
            st_d.s2 = st_q.s1;
            if (st_q.s1.op == OP_RD) begin
                st_d.rd = fresh_word;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign drive_en = (st_q.s2.op == OP_RD) && !oe_n;
    assign dq       = drive_en ? st_q.rd : 'z;

endmodule

// File: rtl/zbt_sram_chk.sv
module zbt_sram_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       clk_en_n,
    input logic       adv_ld,
    input logic       sel1_n,
    input logic       sel2,
    input logic       sel3_n,
    input logic [1:0] s1_op,
    input logic [1:0] s2_op,
    input logic [1:0] burst_cnt,
    input logic       burst_wr,
    input logic       burst_active,
    input logic       drive_en
);
    logic chosen;
    assign chosen = !sel1_n && sel2 && !sel3_n;

    // R1: a held clock freezes the pipeline and the beat counter
    assert_stall_freeze_R1: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en_n |=> ($stable(s1_op) && $stable(s2_op) && $stable(burst_cnt)));

    // R2: a load without full selection issues no access
    assert_deselect_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_n && !adv_ld && !chosen) |=> (s1_op == 2'd0));

    // R2: a load with full selection issues an access
    assert_select_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_n && !adv_ld && chosen) |=> (s1_op != 2'd0));

    // R3: each enabled advance steps the beat counter by one
    assert_counter_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_n && adv_ld) |=> (burst_cnt == $past(burst_cnt) + 2'd1));

    // R4: advances keep the burst's access type
    assert_type_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_n && adv_ld && burst_active) |=>
            ((burst_wr == $past(burst_wr)) && (s1_op == (burst_wr ? 2'd2 : 2'd1))));

    // R9: a non-read entering stage 2 releases the bus
    assert_bus_drain_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_n && (s1_op != 2'd1)) |=> !drive_en);

endmodule

bind zbt_sram zbt_sram_chk i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .clk_en_n     (clk_en_n),
    .adv_ld       (adv_ld),
    .sel1_n       (sel1_n),
    .sel2         (sel2),
    .sel3_n       (sel3_n),
    .s1_op        (st_q.s1.op),
    .s2_op        (st_q.s2.op),
    .burst_cnt    (st_q.cnt),
    .burst_wr     (st_q.is_wr),
    .burst_active (st_q.active),
    .drive_en     (drive_en)
);

// File: tb/test_zbt_sram.sv
module test_zbt_sram;
    localparam int AW = 6;
    localparam int LW = 9;
    localparam int DW = 18;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic          rst_n, cen_n, s1n, s2, s3n, adv, wen, ilv, oen;
    logic [1:0]    bwn;
    logic [AW-1:0] a;
    tri1  [DW-1:0] dq;
    logic [DW-1:0] drv;
    logic          drv_en;
    assign dq = drv_en ? drv : 'z;

    zbt_sram i_zbt_sram (
        .clk(clk), .rst_n(rst_n), .clk_en_n(cen_n), .sel1_n(s1n), .sel2(s2),
        .sel3_n(s3n), .adv_ld(adv), .we_n(wen), .bwe_n(bwn), .interleave(ilv),
        .oe_n(oen), .addr(a), .dq(dq)
    );

    int checks = 0;
    int errors = 0;
    logic [DW-1:0] ref_mem [64];
    logic [DW-1:0] dctr = 18'h00123;

    typedef struct {
        bit            v;
        bit            wr;
        bit            rd;
        bit            fwd;
        bit            is_adv;
        logic [AW-1:0] ad;
        logic [1:0]    ln;
        logic [DW-1:0] dat;
    } slot_t;

    slot_t h1, h2;
    bit            m_act, m_wr;
    logic [AW-1:0] m_base;
    logic [1:0]    m_cnt;
    bit            g_oen = 1'b0;
    string         g_tag = "";

    task automatic check(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [AW-1:0] beat_of(input logic [AW-1:0] base, input logic [1:0] k, input bit il);
        logic [1:0] lo;
        lo = il ? (base[1:0] ^ k) : (base[1:0] + k);
        return {base[AW-1:2], lo};
    endfunction

    function automatic slot_t empty_slot();
        slot_t s;
        s.v = 0; s.wr = 0; s.rd = 0; s.fwd = 0; s.is_adv = 0;
        s.ad = '0; s.ln = '0; s.dat = '0;
        return s;
    endfunction

    task automatic cycle(input bit c_n, input bit l_adv, input bit e1n, input bit e2, input bit e3n,
                         input bit l_wn, input logic [1:0] l_bwn, input logic [AW-1:0] l_a, input bit l_il);
        slot_t nw;
        string tg;
        @(negedge clk);
        cen_n = c_n; adv = l_adv; s1n = e1n; s2 = e2; s3n = e3n;
        wen = l_wn; bwn = l_bwn; a = l_a; ilv = l_il; oen = g_oen;
        if (h2.v && h2.wr) begin
            drv = h2.dat; drv_en = 1'b1;
        end else begin
            drv_en = 1'b0;
        end
        #1;
        if (h2.v && h2.rd && !g_oen) begin
            tg = h2.fwd ? "R8" : (h2.is_adv ? "R5" : "R7");
            if (g_tag != "") tg = g_tag;
            if (c_n) tg = "R1";
            check(dq == ref_mem[h2.ad], tg, dq, ref_mem[h2.ad]);
        end else if (!(h2.v && h2.wr)) begin
            tg = (h2.v && h2.rd) ? "R7" : "R9";
            if (g_tag != "") tg = g_tag;
            check(dq === {DW{1'b1}}, tg, dq, {DW{1'b1}});
        end
        if (!c_n && h2.v && h2.wr) begin
            if (h2.ln[0]) ref_mem[h2.ad][LW-1:0]  = h2.dat[LW-1:0];
            if (h2.ln[1]) ref_mem[h2.ad][DW-1:LW] = h2.dat[DW-1:LW];
        end
        if (!c_n) begin
            nw = empty_slot();
            if (!l_adv) begin
                if (!e1n && e2 && !e3n) begin
                    m_act = 1; m_wr = !l_wn; m_base = l_a; m_cnt = 0;
                    nw.v = 1; nw.ad = l_a;
                end else begin
                    m_act = 0;
                end
            end else begin
                m_cnt = m_cnt + 2'd1;
                if (m_act) begin
                    nw.v = 1; nw.is_adv = 1;
                    nw.ad = beat_of(m_base, m_cnt, l_il);
                end
            end
            nw.wr  = nw.v && m_wr;
            nw.rd  = nw.v && !m_wr;
            nw.ln  = ~l_bwn;
            nw.fwd = nw.rd && h1.v && h1.wr && (h1.ad == nw.ad);
            dctr   = dctr + 18'h00925;
            nw.dat = {1'b0, dctr[15:8], 1'b0, dctr[7:0]};
            @(posedge clk);
            h2 = h1;
            h1 = nw;
        end else begin
            @(posedge clk);
        end
    endtask

    task automatic ld_w(input logic [AW-1:0] ad, input logic [1:0] m, input bit il);
        cycle(0, 0, 0, 1, 0, 0, m, ad, il);
    endtask
    task automatic ld_r(input logic [AW-1:0] ad, input bit il);
        cycle(0, 0, 0, 1, 0, 1, 2'b11, ad, il);
    endtask
    // advance with chip selects deasserted and an address that must be ignored
    task automatic adv_b(input logic [1:0] m, input bit il, input bit wn);
        cycle(0, 1, 1, 0, 1, wn, m, 6'h3f, il);
    endtask
    task automatic nop();
        cycle(0, 0, 1, 0, 1, 1, 2'b11, 6'h00, 0);
    endtask
    // stalled cycle showing a selected write load that must be ignored
    task automatic hold();
        cycle(1, 0, 0, 1, 0, 0, 2'b00, 6'h15, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        h1 = empty_slot(); h2 = empty_slot();
        m_act = 0; m_wr = 0; m_base = '0; m_cnt = '0;
        rst_n = 0; cen_n = 0; s1n = 1; s2 = 0; s3n = 1; adv = 0; wen = 1;
        bwn = 2'b11; a = '0; ilv = 0; oen = 0; drv = '0; drv_en = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(dq === {DW{1'b1}}, "R10", dq, {DW{1'b1}});
        rst_n = 1;
        @(negedge clk);
        check(dq === {DW{1'b1}}, "R10", dq, {DW{1'b1}});

        // fill every word with full-lane bursts, alternating order and start
        for (int b = 0; b < 16; b++) begin
            ld_w(AW'(b * 4 + b % 4), 2'b00, b[0]);
            for (int k = 0; k < 3; k++) adv_b(2'b00, b[0], 1);
        end
        nop(); nop();

        // read every word back in the other order with another start (R5, R7)
        for (int b = 0; b < 16; b++) begin
            ld_r(AW'(b * 4 + (b + 1) % 4), !b[0]);
            for (int k = 0; k < 3; k++) adv_b(2'b11, !b[0], 1);
        end
        nop(); nop();

        // R8 / R6: write immediately followed by a read of the same word, all masks
        for (int i = 0; i < 8; i++) begin
            if (i % 4 == 3) g_tag = "R6";
            ld_w(AW'(i * 5 + 2), 2'(i % 4), 0);
            ld_r(AW'(i * 5 + 2), 0);
            g_tag = "";
        end
        nop(); nop();

        // R1: forwarding pair with stalls in between, and a burst read under stalls
        ld_w(6'h21, 2'b10, 0);
        hold();
        ld_r(6'h21, 0);
        hold(); hold();
        nop();
        hold();
        nop();
        g_tag = "R1";
        ld_r(6'h21, 0);
        nop();
        g_tag = "";
        ld_r(6'h30, 1);
        hold();
        adv_b(2'b11, 1, 1);
        hold();
        adv_b(2'b11, 1, 1);
        adv_b(2'b11, 1, 1);
        hold();
        nop(); nop();

        // R4: a read burst whose advances show a write enable
        g_tag = "R4";
        ld_r(6'h08, 0);
        adv_b(2'b00, 0, 0);
        adv_b(2'b00, 0, 0);
        adv_b(2'b00, 0, 0);
        nop(); nop();
        // and a write burst whose advances show a read
        ld_w(6'h0d, 2'b00, 1);
        adv_b(2'b00, 1, 1);
        adv_b(2'b00, 1, 1);
        adv_b(2'b00, 1, 1);
        nop(); nop();
        ld_r(6'h0c, 0);
        for (int k = 0; k < 3; k++) adv_b(2'b11, 0, 1);
        nop(); nop();
        g_tag = "";

        // R3: advances after a deselect access nothing
        g_tag = "R3";
        nop();
        adv_b(2'b00, 0, 0);
        adv_b(2'b00, 0, 0);
        adv_b(2'b00, 0, 1);
        nop(); nop();
        g_tag = "";

        // R2: each chip select alone withheld on a write load
        g_tag = "R2";
        cycle(0, 0, 1, 1, 0, 0, 2'b00, 6'h11, 0);
        cycle(0, 0, 0, 0, 0, 0, 2'b00, 6'h12, 0);
        cycle(0, 0, 0, 1, 1, 0, 2'b00, 6'h13, 0);
        nop(); nop();
        ld_r(6'h11, 0); ld_r(6'h12, 0); ld_r(6'h13, 0);
        nop(); nop();
        g_tag = "";

        // R7: output enable high during read slots keeps the bus released
        ld_r(6'h04, 0);
        adv_b(2'b11, 0, 1);
        g_oen = 1'b1;
        adv_b(2'b11, 0, 1);
        adv_b(2'b11, 0, 1);
        g_oen = 1'b0;
        nop(); nop();

        // R9: write directly after read, then reading the result
        ld_r(6'h3a, 0);
        ld_w(6'h3b, 2'b01, 0);
        ld_r(6'h3b, 1);
        nop(); nop();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule